// File: doc/BRIEF.md
# Synchronous Receive Character Hunt

This block is the front end of a synchronous serial receiver. The serial stream carries no start or stop bits. The block first has to find where characters begin, and only then can it hand characters to the rest of the receiver. A one-cycle bit strobe qualifies each serial bit. Bits arrive least significant first.

In internal mode the block shifts every incoming bit into a window and compares the window with a programmed sync pattern on every bit. It does not wait for a character boundary. Software can ask for one sync pattern or for two back-to-back patterns. In external mode the internal comparison is switched off, and a high level on a sync input declares alignment. Once aligned, the block raises a sync flag and assembles fixed-length characters, each with an optional parity bit. It delivers every character with a one-cycle valid strobe and a parity error flag. A hunt command drops alignment and starts the search again.

Top module: `sync_hunt_rx`

## Requirements
- R1: After reset `sync_det`, `rx_strobe` and `rx_perr` are 0, and the block is hunting for sync.
- R2: In internal mode (`ext_mode`=0) with `two_sync`=0, the window is compared with `sync_a` on every strobed bit once the window holds one full frame. The frame is L data bits, where L = 5 + `len_sel` (`len_sel` 0..3 gives 5..8), plus one parity bit when `par_en`=1. Only the low L bits take part in the comparison, and any parity bit of the sync frame is ignored. On a match, `sync_det` reads 1 from the cycle after the strobe edge, and the next strobed bit is bit 0 of the first data character.
- R3: With `two_sync`=1, a match against `sync_a` must be followed by exactly one frame whose data equals `sync_b`. Only then is `sync_det` set. Otherwise `sync_det` stays 0 and hunting resumes from the next bit.
- R4: In external mode, a cycle in which `ext_sync` is 1 during the hunt sets `sync_det`, and the next strobed bit is bit 0 of the first character. A strobed bit in that same cycle is discarded. In external mode, pattern matches have no effect. In internal mode, `ext_sync` has no effect.
- R5: After alignment, every frame produces one character. Bits arrive LSB first. `rx_char` carries the L data bits with its upper bits 0. `rx_strobe` is high for exactly the one cycle after the edge that takes the frame's last bit. No character is produced while hunting.
- R6: When `par_en`=1, the bit after the data bits is parity. `par_odd`=1 selects odd parity and `par_odd`=0 selects even parity. `rx_perr` is 1 with `rx_strobe` when the data bits and the parity bit together break the selected parity. With `par_en`=0, `rx_perr` is 0.
- R7: `status_rd` clears `sync_det` on the next edge. If a sync is found in that same cycle, `sync_det` is set and the read does not clear it.
- R8: `hunt_cmd` returns the block to the hunt state, clears `sync_det`, empties the window and discards a bit strobed in the same cycle. No character follows until sync is found again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_stb | input | 1 | One-cycle strobe qualifying `bit_in` (receive clock) |
| bit_in | input | 1 | Serial data bit |
| len_sel | input | 2 | Character length select, L = 5 + value |
| par_en | input | 1 | Parity bit present after the data bits |
| par_odd | input | 1 | 1 = odd parity, 0 = even parity |
| sync_a | input | 8 | First sync pattern |
| sync_b | input | 8 | Second sync pattern |
| two_sync | input | 1 | Require two consecutive sync patterns |
| ext_mode | input | 1 | 1 = external sync input, 0 = internal pattern match |
| ext_sync | input | 1 | External sync-detect level |
| hunt_cmd | input | 1 | Enter hunt |
| status_rd | input | 1 | Status read, clears the sync flag |
| sync_det | output | 1 | Sync detected flag |
| rx_char | output | 8 | Aligned received character |
| rx_strobe | output | 1 | One-cycle character valid |
| rx_perr | output | 1 | Parity error for the character on `rx_char` |

## Verification
A sync event and a status read can land in the same cycle and compete for `sync_det`. The bench raises `ext_sync` and `status_rd` together during an external-mode hunt. It then expects the flag to read 1, not 0. It also checks the opposite case: a read with no sync event clears the flag. The received characters go through a scoreboard queue so that alignment after each kind of sync can be judged.

// File: rtl/sync_hunt_pkg.sv
package sync_hunt_pkg;
  typedef enum logic [1:0] {
    ST_HUNT  = 2'd0,
    ST_SYNC2 = 2'd1,
    ST_DATA  = 2'd2
  } hunt_state_e;
endpackage

// File: rtl/sync_hunt_shift.sv
module sync_hunt_shift #(
  parameter int WW = 9
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic          bit_in,
  output logic [WW-1:0] win_nx
);
  logic [WW-1:0] win_q;

  // newest bit enters at the top, so older bits drift toward bit 0
  assign win_nx = {bit_in, win_q[WW-1:1]};

  always_ff @(posedge clk) begin
    if (rst) win_q <= '0;
    else if (en) win_q <= win_nx;
  end
endmodule

// File: rtl/sync_hunt_extract.sv
module sync_hunt_extract #(
  parameter int MIN_BITS = 5,
  parameter int LEN_W    = 2,
  parameter int DW       = 8,
  parameter int WW       = 9,
  parameter int CW       = 4
) (
  input  logic [WW-1:0]    win,
  input  logic [LEN_W-1:0] len_sel,
  input  logic             par_en,
  output logic [DW-1:0]    data,
  output logic             pbit,
  output logic [CW-1:0]    flen
);
  localparam int NLEN = 1 << LEN_W;

  logic [DW-1:0] cand [NLEN];

  for (genvar g = 0; g < NLEN; g++) begin : g_len
    localparam int L = MIN_BITS + g;
    // with parity the newest bit is parity and the data sit just below it
    assign cand[g] = par_en ? DW'(win[WW-2 -: L]) : DW'(win[WW-1 -: L]);
  end

  assign data = cand[len_sel];
  assign pbit = win[WW-1];
  assign flen = CW'(MIN_BITS) + CW'(len_sel) + CW'(par_en);
endmodule

// File: rtl/sync_hunt_cmp.sv
module sync_hunt_cmp #(
  parameter int MIN_BITS = 5,
  parameter int LEN_W    = 2,
  parameter int DW       = 8,
  parameter int NS       = 2
) (
  input  logic [DW-1:0]         data,
  input  logic [LEN_W-1:0]      len_sel,
  input  logic [NS-1:0][DW-1:0] pats,
  output logic [NS-1:0]         hit
);
  logic [DW-1:0] mask;

  always_comb begin
    for (int i = 0; i < DW; i++) mask[i] = (i < MIN_BITS + int'(len_sel));
  end

  for (genvar s = 0; s < NS; s++) begin : g_pat
    assign hit[s] = (data == (pats[s] & mask));
  end
endmodule

// File: rtl/sync_hunt_parity.sv
module sync_hunt_parity #(
  parameter int DW = 8
) (
  input  logic [DW-1:0] data,
  input  logic          pbit,
  input  logic          par_en,
  input  logic          par_odd,
  output logic          perr
);
  assign perr = par_en & ((^data ^ pbit) != par_odd);
endmodule

// File: rtl/sync_hunt_rx.sv
module sync_hunt_rx
  import sync_hunt_pkg::*;
#(
  parameter  int MIN_BITS = 5,
  parameter  int LEN_W    = 2,
  localparam int DW       = MIN_BITS + (1 << LEN_W) - 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bit_stb,
  input  logic             bit_in,
  input  logic [LEN_W-1:0] len_sel,
  input  logic             par_en,
  input  logic             par_odd,
  input  logic [DW-1:0]    sync_a,
  input  logic [DW-1:0]    sync_b,
  input  logic             two_sync,
  input  logic             ext_mode,
  input  logic             ext_sync,
  input  logic             hunt_cmd,
  input  logic             status_rd,
  output logic             sync_det,
  output logic [DW-1:0]    rx_char,
  output logic             rx_strobe,
  output logic             rx_perr
);
  localparam int WW = DW + 1;
  localparam int CW = $clog2(WW + 1);

  hunt_state_e     st_q;
  logic [CW-1:0]   cnt_q, fill_q, cnt_nx, fill_nx, flen;
  logic [WW-1:0]   win_nx;
  logic [DW-1:0]   data;
  logic            pbit, perr, take, frame_done, fill_ok;
  logic [1:0]      hit;
  logic [1:0][DW-1:0] pats;

  // a bit strobed together with a hunt command is dropped
  assign take = bit_stb & ~hunt_cmd;
  assign pats = {sync_b, sync_a};

  sync_hunt_shift #(.WW(WW)) u_shift (
    .clk(clk), .rst(rst | hunt_cmd), .en(take), .bit_in(bit_in), .win_nx(win_nx)
  );

  sync_hunt_extract #(
    .MIN_BITS(MIN_BITS), .LEN_W(LEN_W), .DW(DW), .WW(WW), .CW(CW)
  ) u_extract (
    .win(win_nx), .len_sel(len_sel), .par_en(par_en),
    .data(data), .pbit(pbit), .flen(flen)
  );

  sync_hunt_cmp #(
    .MIN_BITS(MIN_BITS), .LEN_W(LEN_W), .DW(DW), .NS(2)
  ) u_cmp (
    .data(data), .len_sel(len_sel), .pats(pats), .hit(hit)
  );

  sync_hunt_parity #(.DW(DW)) u_par (
    .data(data), .pbit(pbit), .par_en(par_en), .par_odd(par_odd), .perr(perr)
  );

  assign cnt_nx     = cnt_q + CW'(1);
  assign frame_done = (cnt_nx == flen);
  assign fill_nx    = (fill_q == CW'(WW)) ? fill_q : fill_q + CW'(1);
  assign fill_ok    = (fill_nx >= flen);

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q      <= ST_HUNT;
      cnt_q     <= '0;
      fill_q    <= '0;
      sync_det  <= 1'b0;
      rx_char   <= '0;
      rx_strobe <= 1'b0;
      rx_perr   <= 1'b0;
    end else begin
      rx_strobe <= 1'b0;
      if (status_rd) sync_det <= 1'b0;
      if (hunt_cmd) begin
        st_q     <= ST_HUNT;
        cnt_q    <= '0;
        fill_q   <= '0;
        sync_det <= 1'b0;
      end else begin
        unique case (st_q)
          ST_HUNT: begin
            if (ext_mode) begin
              if (ext_sync) begin
                st_q     <= ST_DATA;
                cnt_q    <= '0;
                sync_det <= 1'b1;
              end
            end else if (take) begin
              fill_q <= fill_nx;
              if (fill_ok && hit[0]) begin
                cnt_q <= '0;
                if (two_sync) begin
                  st_q <= ST_SYNC2;
                end else begin
                  st_q     <= ST_DATA;
                  sync_det <= 1'b1;
                end
              end
            end
          end
          ST_SYNC2: begin
            if (take) begin
              if (frame_done) begin
                cnt_q <= '0;
                if (hit[1]) begin
                  st_q     <= ST_DATA;
                  sync_det <= 1'b1;
                end else begin
                  st_q <= ST_HUNT;
                end
              end else begin
                cnt_q <= cnt_nx;
              end
            end
          end
          ST_DATA: begin
            if (take) begin
              if (frame_done) begin
                cnt_q     <= '0;
                rx_strobe <= 1'b1;
                rx_char   <= data;
                rx_perr   <= perr;
              end else begin
                cnt_q <= cnt_nx;
              end
            end
          end
          default: st_q <= ST_HUNT;
        endcase
      end
    end
  end
endmodule

// File: rtl/sync_hunt_rx_chk.sv
module sync_hunt_rx_chk #(
  parameter int MIN_BITS = 5,
  parameter int LEN_W    = 2,
  parameter int DW       = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             bit_stb,
  input logic             ext_mode,
  input logic             ext_sync,
  input logic             hunt_cmd,
  input logic             status_rd,
  input logic             par_en,
  input logic [LEN_W-1:0] len_sel,
  input logic             sync_det,
  input logic [DW-1:0]    rx_char,
  input logic             rx_strobe,
  input logic             rx_perr
);
  p_strobe_single_r5: assert property (@(posedge clk) disable iff (rst)
    rx_strobe |=> !rx_strobe);

  p_strobe_after_bit_r5: assert property (@(posedge clk) disable iff (rst)
    rx_strobe |-> $past(bit_stb));

  p_char_upper_zero_r5: assert property (@(posedge clk) disable iff (rst)
    rx_strobe |-> ((rx_char >> (MIN_BITS + int'($past(len_sel)))) == '0));

  p_perr_needs_parity_r6: assert property (@(posedge clk) disable iff (rst)
    (rx_strobe && !$past(par_en)) |-> !rx_perr);

  p_read_clears_r7: assert property (@(posedge clk) disable iff (rst)
    (status_rd && !bit_stb && !ext_sync && !hunt_cmd) |=> !sync_det);

  p_hunt_clears_r8: assert property (@(posedge clk) disable iff (rst)
    hunt_cmd |=> (!sync_det && !rx_strobe));

  p_sync_has_cause_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(sync_det) |-> $past(!hunt_cmd && (bit_stb || (ext_mode && ext_sync))));

  p_ext_ignored_internal_r4: assert property (@(posedge clk) disable iff (rst)
    (!ext_mode && !bit_stb && !sync_det) |=> !sync_det);
endmodule

bind sync_hunt_rx sync_hunt_rx_chk #(
  .MIN_BITS(MIN_BITS), .LEN_W(LEN_W), .DW(DW)
) u_chk (
  .clk(clk), .rst(rst), .bit_stb(bit_stb), .ext_mode(ext_mode),
  .ext_sync(ext_sync), .hunt_cmd(hunt_cmd), .status_rd(status_rd),
  .par_en(par_en), .len_sel(len_sel), .sync_det(sync_det),
  .rx_char(rx_char), .rx_strobe(rx_strobe), .rx_perr(rx_perr)
);

// File: tb/sync_hunt_rx_bench.sv
module sync_hunt_rx_bench;
  localparam int DW = 8;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst, bit_stb, bit_in, par_en, par_odd, two_sync, ext_mode, ext_sync;
  logic hunt_cmd, status_rd, sync_det, rx_strobe, rx_perr;
  logic [1:0] len_sel;
  logic [DW-1:0] sync_a, sync_b, rx_char;

  sync_hunt_rx u_sync_hunt_rx (
    .clk(clk), .rst(rst), .bit_stb(bit_stb), .bit_in(bit_in), .len_sel(len_sel),
    .par_en(par_en), .par_odd(par_odd), .sync_a(sync_a), .sync_b(sync_b),
    .two_sync(two_sync), .ext_mode(ext_mode), .ext_sync(ext_sync),
    .hunt_cmd(hunt_cmd), .status_rd(status_rd), .sync_det(sync_det),
    .rx_char(rx_char), .rx_strobe(rx_strobe), .rx_perr(rx_perr)
  );

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [DW:0] exp_q[$];
  logic [DW:0] e;

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic send_bit(logic b);
    @(negedge clk);
    bit_in = b;
    bit_stb = 1'b1;
    @(negedge clk);
    bit_stb = 1'b0;
  endtask

  task automatic send_frame(logic [DW-1:0] d, int len, logic pe, logic pb);
    for (int i = 0; i < len; i++) send_bit(d[i]);
    if (pe) send_bit(pb);
  endtask

  function automatic logic even_pbit(logic [DW-1:0] d, int len);
    logic p = 1'b0;
    for (int i = 0; i < len; i++) p ^= d[i];
    return p;
  endfunction

  // scoreboard driver: expected value from the requirements, then the bits
  task automatic expect_char(logic [DW-1:0] d, int len, logic pe, logic po, logic pb);
    logic [DW-1:0] m;
    logic ones, pe_bad;
    m = '0;
    for (int i = 0; i < len; i++) m[i] = d[i];
    ones = even_pbit(m, len) ^ pb;
    pe_bad = pe && (ones != po);
    exp_q.push_back({pe_bad, m});
    send_frame(d, len, pe, pb);
  endtask

  task automatic pulse_hunt();
    @(negedge clk); hunt_cmd = 1'b1;
    @(negedge clk); hunt_cmd = 1'b0;
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (!rst && rx_strobe) begin
      if (exp_q.size() == 0) begin
        checks++; errors++;
        $display("FAIL R5/R8 unexpected char actual %0h expected none", rx_char);
      end else begin
        e = exp_q.pop_front();
        check("R5 char value", 32'(rx_char), 32'(e[DW-1:0]));
        check("R6 parity flag", 32'(rx_perr), 32'(e[DW]));
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual timeout expected finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; bit_stb = 0; bit_in = 0; par_en = 0; par_odd = 0; two_sync = 0;
    ext_mode = 0; ext_sync = 0; hunt_cmd = 0; status_rd = 0;
    len_sel = 2'd3; sync_a = 8'h16; sync_b = 8'h00;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 sync_det after reset", 32'(sync_det), 0);
    check("R1 rx_strobe after reset", 32'(rx_strobe), 0);

    // R2: single internal sync found on an arbitrary bit offset
    send_bit(1); send_bit(0); send_bit(1);
    for (int i = 0; i < 7; i++) send_bit(sync_a[i]);
    check("R2 no sync before last bit", 32'(sync_det), 0);
    send_bit(sync_a[7]);
    check("R2 sync on bitwise match", 32'(sync_det), 1);
    expect_char(8'hA5, 8, 0, 0, 0);
    expect_char(8'h3C, 8, 0, 0, 0);

    // R7: read without a sync event clears the flag, data keeps flowing
    @(negedge clk); status_rd = 1'b1;
    @(negedge clk); status_rd = 1'b0;
    check("R7 read clears sync_det", 32'(sync_det), 0);
    expect_char(8'h5E, 8, 0, 0, 0);

    // R8: hunt command drops alignment; no character from the next frame
    pulse_hunt();
    check("R8 hunt clears sync_det", 32'(sync_det), 0);
    send_frame(8'hFF, 8, 0, 0);
    check("R8 still hunting", 32'(sync_det), 0);

    // R4: external sync input ignored in internal mode
    len_sel = 2'd2; par_en = 1'b1; par_odd = 1'b0; sync_b = 8'h2A; two_sync = 1'b1;
    @(negedge clk); ext_sync = 1'b1;
    @(negedge clk); ext_sync = 1'b0;
    check("R4 ext_sync ignored internal", 32'(sync_det), 0);

    // R3: second pattern wrong -> no sync
    pulse_hunt();
    send_frame(8'h16, 7, 1, even_pbit(8'h16, 7));
    check("R3 first pattern alone", 32'(sync_det), 0);
    send_frame(8'h55, 7, 1, even_pbit(8'h55, 7));
    check("R3 wrong second pattern", 32'(sync_det), 0);

    // R3: correct pair, then R6 parity cases on 7-bit characters
    pulse_hunt();
    send_frame(8'h16, 7, 1, even_pbit(8'h16, 7));
    send_frame(8'h2A, 7, 1, even_pbit(8'h2A, 7));
    check("R3 two patterns in a row", 32'(sync_det), 1);
    expect_char(8'h41, 7, 1, 0, 1'b0);
    expect_char(8'h41, 7, 1, 0, 1'b1);
    par_odd = 1'b1;
    expect_char(8'h41, 7, 1, 1, 1'b1);
    expect_char(8'h41, 7, 1, 1, 1'b0);

    // R4: external mode ignores pattern matches
    pulse_hunt();
    ext_mode = 1'b1; len_sel = 2'd0; par_en = 1'b0; two_sync = 1'b0;
    send_frame(8'h16, 5, 0, 0);
    check("R4 pattern ignored external", 32'(sync_det), 0);

    // R7 and R4: sync event and status read in the same cycle
    @(negedge clk); ext_sync = 1'b1; status_rd = 1'b1;
    @(negedge clk); ext_sync = 1'b0; status_rd = 1'b0;
    check("R7 sync wins over read", 32'(sync_det), 1);
    expect_char(8'h13, 5, 0, 0, 0);
    expect_char(8'h0A, 5, 0, 0, 0);

    repeat (4) @(negedge clk);
    check("R5 all expected chars seen", 32'(exp_q.size()), 0);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule